// File: doc/BRIEF.md
# Selectable Bus Clock Divider

This block derives an expansion-bus clock from a fast core clock. A 3-bit select code, taken from the low bits of an 8-bit configuration byte, picks either an integer divide ratio (4, 5, 6, 8, 10 or 12) or a slower fixed-frequency reference. The reference arrives as a stream of single-cycle enable pulses in the fast clock domain. The block produces a divided clock level, `bus_clk`, and a one-cycle enable pulse, `bus_ce`, which marks each rising edge of that level. Bus logic can then run on the fast clock and use the enable pulse.

A four-state machine generates the clock. The states are `PH_REF_LOW` and `PH_REF_HIGH`, which follow the reference, and `PH_DIV_HIGH` and `PH_DIV_LOW`, which count core cycles. The transitions are:
- From `PH_REF_LOW`, a reference pulse moves the machine to `PH_REF_HIGH` when the select is a reference code. It moves to `PH_DIV_HIGH` when the select is a divide code.
- From `PH_REF_HIGH`, a reference pulse returns the machine to `PH_REF_LOW`.
- From `PH_DIV_HIGH`, the machine moves to `PH_DIV_LOW` when the high phase has lasted its length.
- From `PH_DIV_LOW`, at the end of the period the machine moves to `PH_DIV_HIGH` when the select is a divide code. It moves to `PH_REF_LOW` when the select is a reference code.

The select code is only looked at on the way out of a low state. That point is the place where the clock would next rise. So a code change never cuts a period short.

Top module: `busclk_divider`

## Requirements
- R1: After reset `bus_clk` and `bus_ce` are low and the block is in reference mode. The clock stays low, whatever the select holds, until the first `ref_tick` pulse is sampled.
- R2: Select codes 1, 2, 3, 4, 5 and 6 give a `bus_clk` period of 4, 5, 6, 8, 10 and 12 core cycles respectively.
- R3: For the even ratios, the high phase and the low phase each last half the period.
- R4: For ratio 5 (code 2), the high phase lasts 3 core cycles and the low phase lasts 2.
- R5: With code 0, each sampled `ref_tick` toggles `bus_clk` on that clock edge. The high phase therefore equals the spacing between pulses, and the period equals twice that spacing.
- R6: Code 7 is illegal and gives exactly the behaviour of code 0.
- R7: Bits 7:3 of `cfg_byte` have no effect on the output. Only bits 2:0 form the select code.
- R8: The select is sampled only at a period boundary, which is the edge where `bus_clk` would next rise. Any number of changes inside a period leave that period's high and low lengths unchanged. Only the value present at the boundary takes effect.
- R9: When a divide code is replaced by a reference code, the last divided period keeps its full high phase. Its low phase is then stretched until the next `ref_tick`, so that period is longer than the divide ratio.
- R10: `bus_ce` is high for exactly one core cycle. That cycle is the first cycle in which `bus_clk` is high, and `bus_ce` is never high at any other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse marking each half period of the fixed reference |
| cfg_byte | input | 8 | Configuration byte; bits 2:0 are the select code |
| bus_clk | output | 1 | Generated bus clock level |
| bus_ce | output | 1 | One-cycle pulse at each rising edge of `bus_clk` |

## Verification
The bench goes after the following corner cases:
- **Reset state.** It holds a divide code during reset and withholds reference pulses. A divider that starts counting straight out of reset would raise the clock too early.
- **Late code changes.** It changes the code at the start of a period, sometimes twice. A design that reloads the ratio at once would shorten or stretch that period, or leave a runt high phase.
- **Odd ratio.** It checks the 3/2 split for ratio 5. A truncating half-length calculation would produce 2/3 instead.
- **Illegal and padded codes.** It sends code 7 and codes with the upper bits set. A decoder that treats 7 as a divisor, or that reads the upper bits, would give the wrong period.
- **Switch to reference.** It checks the stretched final low phase when divide mode hands over to the reference.

// File: rtl/busclk_pkg.sv
package busclk_pkg;

    // Largest divide ratio any select code can ask for.
    localparam int unsigned DIV_MAX = 12;

    typedef enum logic [1:0] {
        PH_REF_LOW  = 2'd0,
        PH_REF_HIGH = 2'd1,
        PH_DIV_HIGH = 2'd2,
        PH_DIV_LOW  = 2'd3
    } phase_e;

    // Ratio for a select code; 0 means "follow the reference" (codes 0 and 7).
    function automatic int unsigned divisor_of(input int unsigned code);
        if (code >= 1 && code <= 3)
            return code + 3;
        else if (code >= 4 && code <= 6)
            return code * 2;
        else
            return 0;
    endfunction

    // High phase takes the extra cycle of an odd ratio.
    function automatic int unsigned high_len_of(input int unsigned ratio);
        return (ratio + 1) / 2;
    endfunction

    function automatic logic is_high(input phase_e p);
        return (p == PH_REF_HIGH) || (p == PH_DIV_HIGH);
    endfunction

endpackage

// File: rtl/busclk_code_map.sv
module busclk_code_map #(
    parameter int unsigned SEL_W = 3,
    parameter int unsigned CNT_W = 4
) (
    input  logic [SEL_W-1:0] code,
    output logic             use_ref,
    output logic [CNT_W-1:0] div_len,
    output logic [CNT_W-1:0] hi_len
);

    localparam int unsigned NCODE = 1 << SEL_W;

    logic [NCODE-1:0] hit;
    logic [NCODE-1:0] ref_tbl;
    logic [CNT_W-1:0] div_tbl [NCODE];
    logic [CNT_W-1:0] hi_tbl  [NCODE];

    // One table row per code, computed from the package functions.
    generate
        for (genvar gi = 0; gi < NCODE; gi++) begin : g_code
            localparam int unsigned DV = busclk_pkg::divisor_of(gi);
            assign hit[gi]     = (code == SEL_W'(gi));
            assign ref_tbl[gi] = (DV == 0);           // R6: code 7 joins code 0
            assign div_tbl[gi] = CNT_W'(DV);          // R2
            assign hi_tbl[gi]  = CNT_W'(busclk_pkg::high_len_of(DV)); // R3 R4
        end
    endgenerate

    // One-hot AND-OR select over the rows.
    always_comb begin
        use_ref = 1'b0;
        div_len = '0;
        hi_len  = '0;
        for (int i = 0; i < NCODE; i++) begin
            if (hit[i]) begin
                use_ref = use_ref | ref_tbl[i];
                div_len = div_len | div_tbl[i];
                hi_len  = hi_len  | hi_tbl[i];
            end
        end
    end

endmodule

// File: rtl/busclk_phase_fsm.sv
module busclk_phase_fsm
    import busclk_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             sel_ref,
    input  logic [CNT_W-1:0] sel_div,
    input  logic [CNT_W-1:0] sel_hi,
    output phase_e           phase_q,
    output phase_e           phase_nx,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] div_q,
    output logic             mode_ref
);

    localparam logic [CNT_W-1:0] RST_DIV = CNT_W'(divisor_of(1));
    localparam logic [CNT_W-1:0] RST_HI  = CNT_W'(high_len_of(divisor_of(1)));

    logic [CNT_W-1:0] hi_q;
    logic [CNT_W-1:0] cnt_nx;
    logic [CNT_W-1:0] div_nx;
    logic [CNT_W-1:0] hi_nx;

    // State register: R1 reset into reference mode with the counter cleared.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_REF_LOW;
            cnt_q   <= '0;
            div_q   <= RST_DIV;
            hi_q    <= RST_HI;
        end else begin
            phase_q <= phase_nx;
            cnt_q   <= cnt_nx;
            div_q   <= div_nx;
            hi_q    <= hi_nx;
        end
    end

    // Next state. The select is consulted only where the clock would rise (R8).
    always_comb begin
        phase_nx = phase_q;
        cnt_nx   = cnt_q;
        div_nx   = div_q;
        hi_nx    = hi_q;
        unique case (phase_q)
            PH_REF_LOW: begin
                if (ref_tick) begin
                    if (sel_ref) begin
                        phase_nx = PH_REF_HIGH;          // reference rise (R5)
                    end else begin
                        phase_nx = PH_DIV_HIGH;          // reference -> divide
                        cnt_nx   = '0;
                        div_nx   = sel_div;
                        hi_nx    = sel_hi;
                    end
                end
            end
            PH_REF_HIGH: begin
                if (ref_tick)
                    phase_nx = PH_REF_LOW;               // reference fall (R5)
            end
            PH_DIV_HIGH: begin
                cnt_nx = cnt_q + 1'b1;
                if (cnt_q == hi_q - 1'b1)
                    phase_nx = PH_DIV_LOW;               // divided fall
            end
            PH_DIV_LOW: begin
                if (cnt_q == div_q - 1'b1) begin
                    cnt_nx = '0;
                    if (sel_ref) begin
                        phase_nx = PH_REF_LOW;           // divide -> reference (R9)
                    end else begin
                        phase_nx = PH_DIV_HIGH;          // divided wrap
                        div_nx   = sel_div;
                        hi_nx    = sel_hi;
                    end
                end else begin
                    cnt_nx = cnt_q + 1'b1;
                end
            end
            default: phase_nx = PH_REF_LOW;
        endcase
    end

    assign mode_ref = (phase_q == PH_REF_LOW) || (phase_q == PH_REF_HIGH);

endmodule

// File: rtl/busclk_edge_out.sv
module busclk_edge_out
    import busclk_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e phase_q,
    input  phase_e phase_nx,
    output logic   bus_clk,
    output logic   bus_ce
);

    // Outputs are registered from the next state, so they are glitch-free flops.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_clk <= 1'b0;
            bus_ce  <= 1'b0;
        end else begin
            bus_clk <= is_high(phase_nx);
            bus_ce  <= is_high(phase_nx) && !is_high(phase_q); // R10
        end
    end

endmodule

// File: rtl/busclk_divider.sv
module busclk_divider #(
    parameter int unsigned CFG_W = 8,
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic [CFG_W-1:0] cfg_byte,
    output logic             bus_clk,
    output logic             bus_ce
);

    localparam int unsigned CNT_W = $clog2(busclk_pkg::DIV_MAX);

    logic [SEL_W-1:0] sel_code;
    logic             cfg_hi_unused;
    logic             sel_ref;
    logic [CNT_W-1:0] sel_div;
    logic [CNT_W-1:0] sel_hi;
    busclk_pkg::phase_e phase_q;
    busclk_pkg::phase_e phase_nx;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] div_q;
    logic             mode_ref;

    // R7: only the low field selects; the upper bits go nowhere.
    assign sel_code      = cfg_byte[SEL_W-1:0];
    assign cfg_hi_unused = ^cfg_byte[CFG_W-1:SEL_W];

    busclk_code_map #(
        .SEL_W (SEL_W),
        .CNT_W (CNT_W)
    ) i_code_map (
        .code    (sel_code),
        .use_ref (sel_ref),
        .div_len (sel_div),
        .hi_len  (sel_hi)
    );

    busclk_phase_fsm #(
        .CNT_W (CNT_W)
    ) i_phase_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .sel_ref  (sel_ref),
        .sel_div  (sel_div),
        .sel_hi   (sel_hi),
        .phase_q  (phase_q),
        .phase_nx (phase_nx),
        .cnt_q    (cnt_q),
        .div_q    (div_q),
        .mode_ref (mode_ref)
    );

    busclk_edge_out i_edge_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_q  (phase_q),
        .phase_nx (phase_nx),
        .bus_clk  (bus_clk),
        .bus_ce   (bus_ce)
    );

endmodule

// File: rtl/busclk_divider_chk.sv
module busclk_divider_chk #(
    parameter int unsigned CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_tick,
    input logic             bus_clk,
    input logic             bus_ce,
    input logic             mode_ref,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] div_q
);

    AST_CE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ce |-> (bus_clk && !$past(bus_clk))); // R10

    AST_RISE_GIVES_CE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_clk) |-> bus_ce); // R10

    AST_REF_RISE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_clk) && mode_ref) |-> $past(ref_tick)); // R5

    AST_CNT_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < div_q); // R2

    AST_DIV_HELD_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_q) |-> $rose(bus_clk)); // R8

endmodule

bind busclk_divider busclk_divider_chk #(.CNT_W(CNT_W)) i_busclk_divider_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .bus_clk  (bus_clk),
    .bus_ce   (bus_ce),
    .mode_ref (mode_ref),
    .cnt_q    (cnt_q),
    .div_q    (div_q)
);

// File: tb/test_busclk_divider.sv
module test_busclk_divider;

    localparam int REF_GAP = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic [7:0] cfg_byte = 8'h01;
    logic       bus_clk;
    logic       bus_ce;

    int  checks = 0;
    int  failures = 0;
    bit  tick_en = 1'b0;
    bit  mon_on = 1'b0;
    bit  done = 1'b0;
    bit  cur_ref = 1'b0;

    typedef struct {
        int    hi;
        int    tot;
        bit    exact;
        string req;
    } per_t;

    per_t exp_q[$];

    // monitor state
    int m_hi = 0;
    int m_tot = 0;
    bit m_started = 1'b0;
    bit m_prev = 1'b0;

    always #2 clk = ~clk;

    busclk_divider i_busclk_divider (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .cfg_byte (cfg_byte),
        .bus_clk  (bus_clk),
        .bus_ce   (bus_ce)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Expected ratio from the select code (R2); 0 means reference mode (R5, R6).
    function automatic int exp_div(input int c);
        if (c >= 1 && c <= 3) return c + 3;
        if (c >= 4 && c <= 6) return 2 * c;
        return 0;
    endfunction

    function automatic per_t item_for(input int c);
        per_t it;
        int n;
        n = exp_div(c);
        if (n == 0) begin
            it.hi = REF_GAP; it.tot = 2 * REF_GAP; it.exact = 1'b1;
            it.req = (c == 7) ? "R6" : "R5";
        end else begin
            it.hi = (n + 1) / 2; it.tot = n; it.exact = 1'b1;
            it.req = (n == 5) ? "R2,R4" : "R2,R3";
        end
        return it;
    endfunction

    // Reference pulse stream, one pulse every REF_GAP cycles once enabled.
    initial begin
        wait (tick_en);
        forever begin
            repeat (REF_GAP - 1) @(negedge clk);
            ref_tick = 1'b1;
            @(negedge clk);
            ref_tick = 1'b0;
        end
    end

    // Monitor: measures each completed period and compares it with the queue.
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (bus_ce) begin
                    chk(bus_clk && !m_prev, "R10", "pulse without rising edge",
                        int'({m_prev, bus_clk}), 1);
                    if (m_started) begin
                        if (exp_q.size() == 0) begin
                            chk(1'b0, "R8", "period with no expectation", m_tot, 0);
                        end else begin
                            per_t e;
                            e = exp_q.pop_front();
                            chk(m_hi == e.hi, e.req, "high cycles", m_hi, e.hi);
                            if (e.exact)
                                chk(m_tot == e.tot, e.req, "period cycles", m_tot, e.tot);
                            else
                                chk(m_tot > e.tot, e.req, "stretched period cycles",
                                    m_tot, e.tot + 1);
                        end
                    end
                    m_started = 1'b1;
                    m_hi = 1;
                    m_tot = 1;
                end else begin
                    if (bus_clk && !m_prev)
                        chk(1'b0, "R10", "rising edge without pulse", int'(bus_ce), 1);
                    if (m_started) begin
                        m_tot++;
                        if (bus_clk) m_hi++;
                    end
                end
                m_prev = bus_clk;
            end
        end
    end

    task automatic wait_ce();
        do begin
            @(negedge clk);
            #1;
        end while (!bus_ce);
    endtask

    // Driver: called just after a period start; queues the periods of the new code.
    task automatic phase(input logic [7:0] cfg, input int n, input bit junk,
                         input string tag);
        int c;
        c = int'(cfg[2:0]);
        if (junk) begin
            cfg_byte = (c == 6) ? 8'h02 : 8'h06;   // R8: transient value inside the period
            @(negedge clk);
            #1;
        end
        cfg_byte = cfg;
        if (exp_div(c) == 0 && !cur_ref && exp_q.size() > 0) begin
            per_t last;
            last = exp_q.pop_back();
            last.exact = 1'b0;
            last.req = "R9";
            exp_q.push_back(last);
        end
        for (int k = 0; k < n; k++) begin
            per_t it;
            it = item_for(c);
            if (tag != "") it.req = {it.req, ",", tag};
            exp_q.push_back(it);
        end
        cur_ref = (exp_div(c) == 0);
        repeat (n) wait_ce();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        cfg_byte = 8'h01;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        chk(!bus_clk && !bus_ce, "R1", "outputs during reset",
            int'({bus_clk, bus_ce}), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        // R1: a divide code is present but no reference pulse yet -> stay low.
        repeat (20) begin
            @(negedge clk);
            chk(!bus_clk && !bus_ce, "R1", "output before first tick",
                int'({bus_clk, bus_ce}), 0);
        end
        tick_en = 1'b1;
        wait_ce();
        begin
            per_t first;
            first = item_for(1);
            first.req = {first.req, ",R1"};
            exp_q.push_back(first);
            cur_ref = 1'b0;
        end
        phase(8'h00, 2, 1'b0, "");
        phase(8'h02, 3, 1'b0, "");
        phase(8'h03, 3, 1'b1, "R8");
        phase(8'h04, 2, 1'b0, "");
        phase(8'h01, 3, 1'b0, "");
        phase(8'h05, 2, 1'b1, "R8");
        phase(8'h06, 2, 1'b0, "");
        phase(8'h07, 2, 1'b0, "");
        phase(8'hFA, 3, 1'b0, "R7");
        phase(8'hF8, 2, 1'b0, "R7");
        phase(8'h5C, 2, 1'b0, "R7");
        wait_ce();
        chk(exp_q.size() == 0, "R8", "periods left unchecked", exp_q.size(), 0);
        done = 1'b1;
        finish_run();
    end

endmodule